// File: doc/BRIEF.md
# PLL Lock Indicator with Holdover Grace

This block produces the lock status flag of a digital phase-locked loop. Each clock it compares the phase error magnitude from the phase detector against a programmable window. In normal mode it raises the flag only after the error has stayed inside that window without a break for a programmable number of timing ticks. A single sample outside the window drops the flag and restarts the count.

The loop's mode comes from an external mode controller. When the loop falls into holdover while locked, the flag stays high for a fixed grace interval. It falls only if holdover is still active when that interval runs out. Freerun clears the flag on the next clock. All durations count ticks from an internal prescaler, so long intervals need only short counters.

Top module: `lock_indicator`

## Requirements
- R1: While reset is active and on the first clock after it, `lockOut` is 0, and the qualification and grace counts are empty.
- R2: A timing tick occurs on every PRESCALE-th clock edge after reset is released (edges PRESCALE, 2·PRESCALE, ...). Qualification and grace advance only on ticks.
- R3: With `mode` = 0 (normal), `lockOut` rises on the tick that completes `qualTime` consecutive in-window ticks. A `qualTime` of 0 acts as 1. An error equal to `phaseWin` counts as inside the window.
- R4: In normal mode, a clock with `phaseErr` > `phaseWin` clears `lockOut` and the qualification count at that edge.
- R5: When `mode` = 1 (holdover) is entered with `lockOut` high, `lockOut` stays high and falls on the GRACE_TICKS-th tick spent in holdover.
- R6: In holdover, `phaseErr` has no effect, and a low `lockOut` stays low.
- R7: `mode` = 2 or 3 (freerun) clears `lockOut` and both counts at the next edge.
- R8: Returning to normal before the grace interval ends, with the error in the window, keeps `lockOut` high without requalification. A later holdover entry starts a fresh full grace interval.
- R9: Returning to normal with `lockOut` low requires a full `qualTime` of in-window ticks, because holdover clears the qualification count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Loop mode: 0 normal, 1 holdover, 2/3 freerun |
| phaseErr | input | ERR_W | Phase error magnitude |
| phaseWin | input | ERR_W | Lock window limit (inclusive) |
| qualTime | input | QUAL_W | Qualification time in ticks |
| lockOut | output | 1 | Lock status flag |

## Verification
The bench builds the block with PRESCALE = 4 and GRACE_TICKS = 6. A full grace interval therefore lasts only 24 clocks, and qualification times from 0 to 6 finish within a few dozen clocks. At these sizes, thousands of random mode changes and window excursions reach expiry, early return and requalification many times each. The small prescale also keeps tick alignment visible, so an off-by-one in the prescaler or in either limit shifts the flag edge by a whole tick.

// File: rtl/lock_ind_pkg.sv
package lock_ind_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_HOLD     = 2'd1,
    MODE_FREE     = 2'd2,
    MODE_FREE_ALT = 2'd3
  } pll_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic qualClr;
    logic qualInc;
    logic graceClr;
    logic graceInc;
    logic lockSet;
    logic lockClr;
  } lock_strobe_t;

endpackage

// File: rtl/lock_ind_ctrl.sv
module lock_ind_ctrl
  import lock_ind_pkg::*;
(
  input  logic [1:0]   mode,
  input  logic         outside,
  input  logic         tick,
  input  logic         lockQ,
  input  logic         qualDone,
  input  logic         graceDone,
  output lock_strobe_t stb
);

  always_comb begin
    stb = '0;
    case (pll_mode_e'(mode))
      MODE_NORMAL: begin
        stb.graceClr = 1'b1;
        if (outside) begin
          stb.qualClr = 1'b1;
          stb.lockClr = 1'b1;
        end else if (!lockQ && tick) begin
          stb.qualInc = 1'b1;
          stb.lockSet = qualDone;
        end
      end
      MODE_HOLD: begin
        stb.qualClr = 1'b1;
        if (lockQ && tick) begin
          stb.graceInc = 1'b1;
          stb.lockClr  = graceDone;
        end
      end
      default: begin
        stb.qualClr  = 1'b1;
        stb.graceClr = 1'b1;
        stb.lockClr  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/lock_ind_dp.sv
module lock_ind_dp
  import lock_ind_pkg::*;
#(
  parameter int ERR_W       = 16,
  parameter int QUAL_W      = 16,
  parameter int PRESCALE    = 1000,
  parameter int GRACE_TICKS = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ERR_W-1:0]  phaseErr,
  input  logic [ERR_W-1:0]  phaseWin,
  input  logic [QUAL_W-1:0] qualTime,
  input  lock_strobe_t      stb,
  output logic              outside,
  output logic              tick,
  output logic              qualDone,
  output logic              graceDone,
  output logic              lockQ
);

  localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int GRACE_W = $clog2(GRACE_TICKS + 1);
  localparam logic [GRACE_W:0] GRACE_LIM = (GRACE_W + 1)'(GRACE_TICKS);

  logic [QUAL_W-1:0]  qualCnt;
  logic [GRACE_W-1:0] graceCnt;
  logic [QUAL_W:0]    qualLim;

  // tick generator: pass-through or modulo counter
  generate
    if (PRESCALE <= 1) begin : g_noPre
      assign tick = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] preCnt;
      assign tick = (preCnt == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     preCnt <= '0;
        else if (tick) preCnt <= '0;
        else           preCnt <= preCnt + 1'b1;
      end
    end
  endgenerate

  assign outside   = phaseErr > phaseWin;
  assign qualLim   = (qualTime == '0) ? (QUAL_W + 1)'(1) : {1'b0, qualTime};
  assign qualDone  = ({1'b0, qualCnt} + 1'b1) >= qualLim;
  assign graceDone = ({1'b0, graceCnt} + 1'b1) >= GRACE_LIM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            qualCnt <= '0;
    else if (stb.qualClr) qualCnt <= '0;
    else if (stb.qualInc) qualCnt <= qualCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             graceCnt <= '0;
    else if (stb.graceClr) graceCnt <= '0;
    else if (stb.graceInc) graceCnt <= graceCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lockQ <= 1'b0;
    else if (stb.lockClr) lockQ <= 1'b0;
    else if (stb.lockSet) lockQ <= 1'b1;
  end

endmodule

// File: rtl/lock_indicator.sv
module lock_indicator
  import lock_ind_pkg::*;
#(
  parameter int ERR_W       = 16,
  parameter int QUAL_W      = 16,
  parameter int PRESCALE    = 1000,
  parameter int GRACE_TICKS = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [ERR_W-1:0]  phaseErr,
  input  logic [ERR_W-1:0]  phaseWin,
  input  logic [QUAL_W-1:0] qualTime,
  output logic              lockOut
);

  lock_strobe_t stb;
  logic outside, tick, qualDone, graceDone, lockQ;

  lock_ind_ctrl u_ctrl (
    .mode      (mode),
    .outside   (outside),
    .tick      (tick),
    .lockQ     (lockQ),
    .qualDone  (qualDone),
    .graceDone (graceDone),
    .stb       (stb)
  );

  lock_ind_dp #(
    .ERR_W       (ERR_W),
    .QUAL_W      (QUAL_W),
    .PRESCALE    (PRESCALE),
    .GRACE_TICKS (GRACE_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .phaseErr  (phaseErr),
    .phaseWin  (phaseWin),
    .qualTime  (qualTime),
    .stb       (stb),
    .outside   (outside),
    .tick      (tick),
    .qualDone  (qualDone),
    .graceDone (graceDone),
    .lockQ     (lockQ)
  );

  assign lockOut = lockQ;

endmodule

// File: rtl/lock_ind_chk.sv
module lock_ind_chk #(
  parameter int ERR_W  = 16,
  parameter int QUAL_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        mode,
  input logic [ERR_W-1:0]  phaseErr,
  input logic [ERR_W-1:0]  phaseWin,
  input logic [QUAL_W-1:0] qualTime,
  input logic              lockOut
);

  // R7
  freerun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    mode[1] |=> !lockOut);

  // R4
  window_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && phaseErr > phaseWin) |=> !lockOut);

  // R3
  rise_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> ($past(mode) == 2'd0 && $past(phaseErr) <= $past(phaseWin)));

  // R8
  keep_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && mode == 2'd0 && phaseErr <= phaseWin) |=> lockOut);

  // R6
  hold_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lockOut && mode == 2'd1) |=> !lockOut);

endmodule

bind lock_indicator lock_ind_chk #(
  .ERR_W  (ERR_W),
  .QUAL_W (QUAL_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .phaseErr (phaseErr),
  .phaseWin (phaseWin),
  .qualTime (qualTime),
  .lockOut  (lockOut)
);

// File: tb/sim_lock_indicator.sv
module sim_lock_indicator;

  localparam int ERR_W = 8;
  localparam int QUAL_W = 8;
  localparam int P = 4;
  localparam int G = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [ERR_W-1:0] phaseErr = '0;
  logic [ERR_W-1:0] phaseWin = 8'd20;
  logic [QUAL_W-1:0] qualTime = 8'd3;
  logic lockOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit mLock = 0;
  int mQual = 0;
  int mGrace = 0;
  int edgeN = 0;

  always #4 clk = ~clk;

  lock_indicator #(
    .ERR_W(ERR_W), .QUAL_W(QUAL_W), .PRESCALE(P), .GRACE_TICKS(G)
  ) u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .phaseErr(phaseErr),
    .phaseWin(phaseWin), .qualTime(qualTime), .lockOut(lockOut)
  );

  function automatic int qualLimit(int qt);
    return (qt == 0) ? 1 : qt;
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s edge=%0d lockOut actual=%0b expected=%0b", tag, edgeN, act, exp);
    end
  endtask

  // advance one clock; inputs present during the edge feed the reference
  task automatic step(string tag);
    bit tick;
    @(negedge clk);
    edgeN++;
    tick = (edgeN % P) == 0;
    if (mode == 2'd0) begin
      mGrace = 0;
      if (phaseErr > phaseWin) begin
        mQual = 0; mLock = 0;
      end else if (!mLock && tick) begin
        mQual++;
        if (mQual >= qualLimit(int'(qualTime))) mLock = 1;
      end
    end else if (mode == 2'd1) begin
      mQual = 0;
      if (mLock && tick) begin
        mGrace++;
        if (mGrace >= G) mLock = 0;
      end
    end else begin
      mQual = 0; mGrace = 0; mLock = 0;
    end
    check(tag, lockOut, mLock);
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", lockOut, 1'b0);
    rstN = 1'b1;
    edgeN = 0; mLock = 0; mQual = 0; mGrace = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mode = 2'd0; phaseErr = 8'd5; phaseWin = 8'd20; qualTime = 8'd3;
    doReset();
    step("R1");
    check("R1", lockOut, 1'b0);

    // qualification of three ticks, ticks at edges 4, 8, 12
    steps(10, "R2");
    check("R2", lockOut, 1'b0);
    step("R3");
    check("R3", lockOut, 1'b1);

    // error equal to window stays inside
    phaseErr = 8'd20;
    steps(5, "R3");
    check("R3", lockOut, 1'b1);

    // one excursion
    phaseErr = 8'd21;
    step("R4");
    check("R4", lockOut, 1'b0);
    phaseErr = 8'd0;
    steps(4 * P, "R3");

    // holdover expiry, huge error ignored
    mode = 2'd1; phaseErr = 8'd255;
    steps(G * P + P, "R5");
    check("R5", lockOut, 1'b0);
    steps(2 * P, "R6");
    check("R6", lockOut, 1'b0);

    // back to normal with lock low: full qualification
    mode = 2'd0; phaseErr = 8'd1; qualTime = 8'd0;
    steps(3 * P, "R9");
    check("R9", lockOut, 1'b1);

    // early return from holdover keeps lock; next holdover gets full grace
    mode = 2'd1; steps(3 * P, "R8");
    mode = 2'd0; steps(2, "R8");
    check("R8", lockOut, 1'b1);
    mode = 2'd1; steps((G - 1) * P, "R8");
    check("R8", lockOut, 1'b1);
    steps(2 * P, "R5");

    // freerun
    mode = 2'd0; qualTime = 8'd2; steps(3 * P, "R3");
    mode = 2'd3; step("R7");
    check("R7", lockOut, 1'b0);
    mode = 2'd0; steps(3 * P, "R3");
    mode = 2'd2; step("R7");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      string tag;
      if ($urandom % 40 == 0) begin
        int r = int'($urandom % 20);
        mode = (r < 10) ? 2'd0 : (r < 17) ? 2'd1 : 2'(2 + (r & 1));
        qualTime = QUAL_W'($urandom % 7);
      end
      if ($urandom % 25 == 0) phaseErr = ERR_W'(21 + $urandom % 50);
      else                    phaseErr = ERR_W'($urandom % 21);
      if (mode[1])            tag = "R7";
      else if (mode == 2'd1)  tag = mLock ? "R5" : "R6";
      else if (phaseErr > phaseWin) tag = "R4";
      else                    tag = mLock ? "R8" : "R3";
      step(tag);
    end

    // mid-run reset
    mode = 2'd0; phaseErr = 8'd0;
    doReset();
    step("R1");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule